// File: doc/BRIEF.md
# Vertical Format Table Loader

This block builds the vertical format table that a line printer controller uses to step paper. While the controller is in its format-load function, the block takes one byte per cycle whenever a valid strobe is high. Each table entry is 12 bits wide and arrives as two 6-bit halves: the first byte carries the low half and the second carries the high half. Only the low six bits of each byte are used.

Marker bytes frame a load. A start marker empties the table and opens pairing. A stop marker ends the load and tells the stepping logic to return its format pointer to the first line. If a load stops with half an entry pending, the table is invalid. An empty table is also invalid.

The block writes completed entries into an internal memory and shows each write on a write port. It reports the current length and a valid flag. A combinational read port lets the stepping logic fetch any entry. A clear input wipes the whole table. Reset only returns the control state to its idle values and leaves the stored entries in place.

Top module: `vfu_loader`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `tbl_len` is 0, `tbl_valid` is 0, `wr_en` is 0 and `ptr_rst` is 0. The loader is in its idle pairing state.
- R2: An accepted byte of value 0xEC, 0xED or 0xEE is a start marker. It sets `tbl_len` to 0 from the next cycle and puts pairing in the even state. Any half-entry that is pending is discarded.
- R3: In the even state, an accepted data byte stores its bits 5:0 as the low half of an entry. It causes no write, and pairing moves to the odd state.
- R4: In the odd state, an accepted data byte completes the entry {byte[5:0], low half}. In the next cycle `wr_en` is 1 for one cycle, `wr_addr` holds the old length and `wr_data` holds the entry. `tbl_len` is one higher, and pairing returns to even. Bits 7:6 of a data byte are ignored.
- R5: An accepted byte of value 0xEF is the stop marker. It makes `ptr_rst` high for exactly the next cycle and returns pairing to idle.
- R6: A stop marker accepted in the odd state sets `tbl_len` to 0. A stop marker in the even or idle state leaves `tbl_len` unchanged.
- R7: At most 143 entries are kept. A completed pair that arrives while `tbl_len` is 143 is dropped: there is no write, the length does not change, and pairing still returns to even.
- R8: `tbl_valid` is 1 exactly when `tbl_len` is nonzero.
- R9: In these cases a byte changes nothing, and pairing is left unchanged except as stated:
  - A data byte in the idle state is ignored.
  - A byte with `byte_vld` low is ignored.
  - A byte with `load_en` low is ignored, and any cycle with `load_en` low returns pairing to idle.
- R10: A `clr` pulse has priority over any byte in the same cycle. From the next cycle every entry reads as 0, `tbl_len` is 0, `ptr_rst` is high for one cycle, no write is reported, and pairing is idle.
- R11: Reset leaves the stored entries unchanged.
- R12: `rd_data` shows, in the same cycle, the entry at `rd_addr`. Addresses of 143 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Controller is in the format-load function |
| byte_vld | input | 1 | A byte is present on `byte_in` |
| byte_in | input | 8 | Incoming byte |
| clr | input | 1 | Wipe the table, length and pointer |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 12 | Entry at `rd_addr` |
| tbl_len | output | 8 | Number of valid entries |
| tbl_valid | output | 1 | Table is usable (length nonzero) |
| wr_en | output | 1 | An entry was written in the previous cycle |
| wr_addr | output | 8 | Address of the reported write |
| wr_data | output | 12 | Value of the reported write |
| ptr_rst | output | 1 | One-cycle request to reset the format pointer |

## Verification
Two of the block's functions can fall in the same cycle: a wipe and the completion of an entry.

To provoke this, the bench raises `clr` in the cycle where the second half of a pair is accepted. It then judges the outcome against its own model of the table:
- no write is reported;
- the length reads 0;
- the pointer-reset pulse appears;
- every address reads 0.

A second overlap occurs when a start or stop marker arrives while a half-entry is pending. Here the bench checks two things. The pending half must not leak into the next pair. A stop in that state must leave the length at 0.

// File: rtl/vfu_loader.sv
module vfu_loader #(
  parameter int          DEPTH     = 143,
  parameter int          HALF_W    = 6,
  parameter logic [7:0]  START_LO  = 8'hEC,
  parameter logic [7:0]  START_HI  = 8'hEE,
  parameter logic [7:0]  STOP_CODE = 8'hEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic                byte_vld,
  input  logic [7:0]          byte_in,
  input  logic                clr,
  input  logic [7:0]          rd_addr,
  output logic [2*HALF_W-1:0] rd_data,
  output logic [7:0]          tbl_len,
  output logic                tbl_valid,
  output logic                wr_en,
  output logic [7:0]          wr_addr,
  output logic [2*HALF_W-1:0] wr_data,
  output logic                ptr_rst
);
  localparam int ENT_W = 2 * HALF_W;
  localparam logic [7:0] FULL = 8'(DEPTH);

  typedef enum logic [1:0] {PH_IDLE, PH_EVEN, PH_ODD} phase_t;

  phase_t             phase;
  logic [HALF_W-1:0]  lo_half;
  logic [ENT_W-1:0]   mem [DEPTH];

  wire take     = load_en & byte_vld & ~clr;
  wire is_start = (byte_in >= START_LO) && (byte_in <= START_HI);
  wire is_stop  = (byte_in == STOP_CODE);
  wire is_data  = !is_start && !is_stop;
  wire room     = tbl_len < FULL;
  wire do_write = take && is_data && (phase == PH_ODD) && room;
  wire [ENT_W-1:0] entry = {byte_in[HALF_W-1:0], lo_half};

  assign tbl_valid = |tbl_len;
  assign rd_data   = (rd_addr < FULL) ? mem[rd_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      tbl_len <= '0;
      lo_half <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      ptr_rst <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      ptr_rst <= 1'b0;
      if (clr) begin
        phase   <= PH_IDLE;
        tbl_len <= '0;
        ptr_rst <= 1'b1;
      end else if (!load_en) begin
        phase <= PH_IDLE;
      end else if (byte_vld) begin
        if (is_start) begin
          tbl_len <= '0;
          phase   <= PH_EVEN;
        end else if (is_stop) begin
          ptr_rst <= 1'b1;
          phase   <= PH_IDLE;
          if (phase == PH_ODD) tbl_len <= '0;
        end else begin
          case (phase)
            PH_EVEN: begin
              lo_half <= byte_in[HALF_W-1:0];
              phase   <= PH_ODD;
            end
            PH_ODD: begin
              phase <= PH_EVEN;
              if (room) begin
                wr_en   <= 1'b1;
                wr_addr <= tbl_len;
                wr_data <= entry;
                tbl_len <= tbl_len + 8'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (do_write) begin
      mem[tbl_len] <= entry;
    end
  end

  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_len <= FULL);

  p_wr_tracks_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (tbl_len == wr_addr + 8'd1));

  p_len_grows_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_len > $past(tbl_len)) |-> (wr_en && tbl_len == $past(tbl_len) + 8'd1));

  p_stop_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_stop) |=> ptr_rst);

  p_start_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_start) |=> (tbl_len == 8'd0 && !wr_en));

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tbl_len == 8'd0 && !wr_en && ptr_rst));

  p_read_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= FULL) |-> (rd_data == '0));
endmodule

// File: tb/vfu_loader_test.sv
module vfu_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 143;

  logic clk = 1'b0, rst_n = 1'b0, load_en = 1'b0, byte_vld = 1'b0, clr = 1'b0;
  logic [7:0] byte_in = '0, rd_addr = '0;
  logic [11:0] rd_data, wr_data;
  logic [7:0] tbl_len, wr_addr;
  logic tbl_valid, wr_en, ptr_rst;

  vfu_loader uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .byte_vld(byte_vld),
    .byte_in(byte_in), .clr(clr), .rd_addr(rd_addr), .rd_data(rd_data),
    .tbl_len(tbl_len), .tbl_valid(tbl_valid), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ptr_rst(ptr_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit mem_known = 0;
  int m_len = 0, m_st = 0, m_lo = 0, m_wv = 0, m_wa = 0, m_wd = 0, m_pr = 0;
  int ref_mem [DEPTH];

  // behavioural model; m_st: 0 idle, 1 even, 2 odd
  always @(posedge clk) begin
    if (!rst_n) begin
      m_len = 0; m_st = 0; m_lo = 0; m_wv = 0; m_pr = 0;
    end else begin
      m_wv = 0; m_pr = 0;
      if (clr) begin
        foreach (ref_mem[i]) ref_mem[i] = 0;
        m_len = 0; m_st = 0; m_pr = 1;
      end else if (!load_en) begin
        m_st = 0;
      end else if (byte_vld) begin
        int b;
        b = int'(byte_in);
        if (b >= 'hEC && b <= 'hEE) begin
          m_len = 0; m_st = 1;
        end else if (b == 'hEF) begin
          m_pr = 1;
          if (m_st == 2) m_len = 0;
          m_st = 0;
        end else if (m_st == 1) begin
          m_lo = b % 64; m_st = 2;
        end else if (m_st == 2) begin
          if (m_len < DEPTH) begin
            ref_mem[m_len] = (b % 64) * 64 + m_lo;
            m_wa = m_len; m_wd = ref_mem[m_len]; m_wv = 1;
            m_len = m_len + 1;
          end
          m_st = 1;
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("tbl_len", int'(tbl_len), m_len);
    chk("tbl_valid (R8)", int'(tbl_valid), int'(m_len != 0));
    chk("wr_en", int'(wr_en), m_wv);
    chk("ptr_rst", int'(ptr_rst), m_pr);
    if (m_wv != 0) begin
      chk("wr_addr", int'(wr_addr), m_wa);
      chk("wr_data", int'(wr_data), m_wd);
    end
    if (mem_known)
      chk("rd_data", int'(rd_data), (rd_addr < DEPTH) ? ref_mem[rd_addr] : 0);
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    rd_addr = 8'($urandom_range(0, 159));
  endtask

  task automatic put(logic [7:0] b);
    byte_vld = 1'b1; byte_in = b;
    cyc();
    byte_vld = 1'b0;
  endtask

  task automatic pair(int v);
    put({2'b01, 6'(v % 64)});
    put({2'b10, 6'((v / 64) % 64)});
  endtask

  task automatic peek(int a);
    rd_addr = 8'(a);
    #1;
    chk("rd_data peek", int'(rd_data), (a < DEPTH) ? ref_mem[a] : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cur_req = "R1";
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    cur_req = "R10";
    clr = 1'b1; cyc(); clr = 1'b0;
    mem_known = 1;
    cyc();

    cur_req = "R9";
    load_en = 1'b1;
    put(8'h11); put(8'h22); cyc();

    cur_req = "R4";
    put(8'hEC);
    pair('h5A3); pair('h0FF); pair('hABC);
    cur_req = "R5";
    put(8'hEF); cyc();
    cur_req = "R12";
    for (int a = 0; a < 5; a++) peek(a);
    peek(150); peek(255);

    cur_req = "R6";
    put(8'hED); pair('h123); put(8'h05); put(8'hEF); cyc();

    cur_req = "R2";
    put(8'hEC); pair('h777); put(8'h3F); put(8'hEE); pair('h246);
    put(8'hEF);
    cur_req = "R3";
    put(8'hEC); put(8'h2A); cyc(); put(8'hEF); cyc();

    cur_req = "R9";
    put(8'hEC); put(8'h01);
    load_en = 1'b0; put(8'h02); load_en = 1'b1;
    put(8'h03); put(8'h04); pair('h9);
    byte_in = 8'h15; cyc(); cyc();
    put(8'hEF);

    cur_req = "R7";
    put(8'hEC);
    for (int k = 0; k < DEPTH + 3; k++) pair(k * 29 + 7);
    put(8'hEF); cyc();
    peek(0); peek(DEPTH - 1); peek(DEPTH);

    cur_req = "R11";
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
    for (int a = 0; a < DEPTH; a += 13) peek(a);

    cur_req = "R10";
    put(8'hEC); put(8'h21);
    byte_vld = 1'b1; byte_in = 8'h4A; clr = 1'b1;
    cyc();
    byte_vld = 1'b0; clr = 1'b0;
    cyc();
    for (int a = 0; a < DEPTH; a += 11) peek(a);
    cur_req = "R8";
    put(8'hED); pair('hFED); put(8'hEF); cyc(); cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule